// File: doc/BRIEF.md
# Asynchronous Bus Read Responder

This block is the slave side of an asynchronous, strobe-handshaked parallel bus. It watches the address, the read/write line, the two transfer-size lines, the address strobe and the data strobe. It passes both strobes through a synchronizer into its own clock domain. When both strobes are active it decides whether the cycle is a read that falls inside its address window. On a hit it fetches the addressed entry from a small local register file, drives that value onto the byte lanes its port width allows, and waits a programmable number of clocks. It then drives the two data-size acknowledge lines with a code that reports its port width to the master.

The acknowledge and the data stay on the bus until the master negates a strobe. Then the block turns off every output enable and returns to idle. Cycles outside the window, and write cycles, are watched until their strobes drop, but the block never drives anything for them. The register file is filled through a simple local load port on the block's own clock; this port is separate from the bus.

The port width is a build-time parameter, 8 or 16 bits. The window is a base/mask pair. All bus outputs are registered, and each is gated by an output enable so that several responders can share the wires.

Top module: `bus_read_responder`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `data_oe_hi`, `data_oe_lo` and `dsack_oe` are low and `dsack_n` is 2'b11.
- R2: A cycle responds only when `(addr & WIN_MASK) == WIN_BASE`. A cycle with any other address leaves every output enable low for its whole length.
- R3: A cycle with `rw` = 0 (write) never enables data or acknowledge, even inside the window.
- R4: On a 16-bit port, a read with `siz` = 2'b10 (word), 2'b00 (long) or 2'b11 (three-byte) enables both lanes. `data_out` then carries register entry `addr[IDX_W:1]`.
- R5: On a 16-bit port, a read with `siz` = 2'b01 (byte) enables only `data_oe_hi` when `addr[0]` = 0, and only `data_oe_lo` when `addr[0]` = 1.
- R6: On an 8-bit port, every read enables `data_oe_hi` only. `data_out[15:8]` carries register entry `addr[IDX_W-1:0]`, and `data_oe_lo` is never set.
- R7: While `dsack_oe` is high, `dsack_n` is 2'b00 on a 16-bit port. On an 8-bit port it is 2'b10, meaning only line 0 is low.
- R8: Suppose `as_n` and `ds_n` are both low at rising edge k. The data lanes are then enabled after edge k+2, and `dsack_oe` rises after edge k+3+W, where W is the `wait_clks` value sampled at edge k+2.
- R9: Once a strobe is high at rising edge m, every output enable is low after edge m+2, and `dsack_n` returns to 2'b11.
- R10: If a strobe is negated before the acknowledge, the data lanes are released as in R9 and `dsack_oe` never rises for that cycle.
- R11: While a lane stays enabled, its bits of `data_out` do not change.
- R12: With `as_n` held low, negating and then reasserting `ds_n` starts a new, fully timed cycle. While both strobes stay low after an acknowledge, no second cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bus address |
| rw | input | 1 | 1 = read, 0 = write |
| siz | input | 2 | Transfer size: 01 byte, 10 word, 11 three-byte, 00 long |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| wait_clks | input | WAIT_W | Extra clocks before acknowledge |
| ld_en | input | 1 | Register file load strobe |
| ld_idx | input | IDX_W | Register file load index |
| ld_data | input | PORT_W | Register file load value |
| data_out | output | 16 | Read data toward the bus |
| data_oe_hi | output | 1 | Drive enable for bits 15:8 |
| data_oe_lo | output | 1 | Drive enable for bits 7:0 |
| dsack_n | output | 2 | Acknowledge code, active low, bit 0 = line 0 |
| dsack_oe | output | 1 | Drive enable for both acknowledge lines |

## Verification
The internal state that matters here is the cycle phase, the wait counter and the latched lane choice. A phase that is stuck or skipped shows up at the enables within one clock of the edge where the reference expects the change. A wrong counter load or decrement moves the rising edge of `dsack_oe` away from edge k+3+W. A wrong lane or index latch shows up as soon as the data lanes turn on, as a wrong enable pair or a wrong `data_out` byte. Every output is compared with a behavioural model on every clock, for two responders of different port width that share one bus, so each such fault is caught in the cycle it first appears.

// File: rtl/resp_pkg.sv
package resp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SKIP    = 2'd1,
    ST_PRESENT = 2'd2,
    ST_ACK     = 2'd3
  } resp_state_e;

  // Active-low acknowledge code that reports the port width to the master.
  function automatic logic [1:0] ack_code(input int port_w);
    return (port_w == 16) ? 2'b00 : 2'b10;
  endfunction

endpackage

// File: rtl/bus_strobe_sync.sv
module bus_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic ds_n,
  output logic as_act,
  output logic ds_act
);

  logic [STAGES-1:0] as_r;
  logic [STAGES-1:0] ds_r;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          as_r[0] <= 1'b1;
          ds_r[0] <= 1'b1;
        end else begin
          as_r[0] <= as_n;
          ds_r[0] <= ds_n;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          as_r[g] <= 1'b1;
          ds_r[g] <= 1'b1;
        end else begin
          as_r[g] <= as_r[g-1];
          ds_r[g] <= ds_r[g-1];
        end
      end
    end
  end

  assign as_act = ~as_r[STAGES-1];
  assign ds_act = ~ds_r[STAGES-1];

endmodule

// File: rtl/bus_window_decode.sv
module bus_window_decode #(
  parameter int                ADDR_W   = 24,
  parameter int                PORT_W   = 16,
  parameter int                IDX_W    = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [ADDR_W-1:0] WIN_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic [1:0]        siz,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  idx,
  output logic              lane_hi,
  output logic              lane_lo
);

  localparam int SHIFT = (PORT_W == 16) ? 1 : 0;

  logic in_window;
  logic byte_xfer;

  assign in_window = ((addr & WIN_MASK) == WIN_BASE);
  assign rd_hit    = in_window & rw;
  assign idx       = addr[IDX_W-1+SHIFT:SHIFT];
  assign byte_xfer = (siz == 2'b01);

  if (PORT_W == 16) begin : g_wide
    always_comb begin
      if (byte_xfer) begin
        lane_hi = ~addr[0];
        lane_lo = addr[0];
      end else begin
        lane_hi = 1'b1;
        lane_lo = 1'b1;
      end
    end
  end else begin : g_narrow
    assign lane_hi = 1'b1;
    assign lane_lo = 1'b0;
  end

endmodule

// File: rtl/resp_regfile.sv
module resp_regfile #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) begin
      mem[ld_idx] <= ld_data;
    end
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/bus_read_responder.sv
module bus_read_responder
  import resp_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                PORT_W      = 16,
  parameter int                IDX_W       = 4,
  parameter int                WAIT_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 24'h004000,
  parameter logic [ADDR_W-1:0] WIN_MASK    = 24'hFFFFE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic [1:0]        siz,
  input  logic              as_n,
  input  logic              ds_n,
  input  logic [WAIT_W-1:0] wait_clks,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [PORT_W-1:0] ld_data,
  output logic [15:0]       data_out,
  output logic              data_oe_hi,
  output logic              data_oe_lo,
  output logic [1:0]        dsack_n,
  output logic              dsack_oe
);

  localparam logic [1:0] DSACK_CODE = ack_code(PORT_W);

  logic              as_act;
  logic              ds_act;
  logic              strobes_on;
  logic              rd_hit;
  logic [IDX_W-1:0]  idx;
  logic              lane_hi;
  logic              lane_lo;
  logic [PORT_W-1:0] rd_data;
  logic [15:0]       placed;
  logic [WAIT_W-1:0] cnt;
  resp_state_e       state;

  bus_strobe_sync #(
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst   (rst),
    .as_n  (as_n),
    .ds_n  (ds_n),
    .as_act(as_act),
    .ds_act(ds_act)
  );

  bus_window_decode #(
    .ADDR_W  (ADDR_W),
    .PORT_W  (PORT_W),
    .IDX_W   (IDX_W),
    .WIN_BASE(WIN_BASE),
    .WIN_MASK(WIN_MASK)
  ) dec_i (
    .addr   (addr),
    .rw     (rw),
    .siz    (siz),
    .rd_hit (rd_hit),
    .idx    (idx),
    .lane_hi(lane_hi),
    .lane_lo(lane_lo)
  );

  resp_regfile #(
    .DATA_W(PORT_W),
    .IDX_W (IDX_W)
  ) rf_i (
    .clk    (clk),
    .ld_en  (ld_en),
    .ld_idx (ld_idx),
    .ld_data(ld_data),
    .rd_idx (idx),
    .rd_data(rd_data)
  );

  if (PORT_W == 16) begin : g_place16
    assign placed = rd_data;
  end else begin : g_place8
    assign placed = {rd_data, 8'h00};
  end

  assign strobes_on = as_act & ds_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      data_out   <= '0;
      data_oe_hi <= 1'b0;
      data_oe_lo <= 1'b0;
      dsack_n    <= 2'b11;
      dsack_oe   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobes_on) begin
            if (rd_hit) begin
              state      <= ST_PRESENT;
              data_out   <= placed;
              data_oe_hi <= lane_hi;
              data_oe_lo <= lane_lo;
              cnt        <= wait_clks;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_SKIP: begin
          if (!strobes_on) begin
            state <= ST_IDLE;
          end
        end
        ST_PRESENT: begin
          if (!strobes_on) begin
            state      <= ST_IDLE;
            data_oe_hi <= 1'b0;
            data_oe_lo <= 1'b0;
          end else if (cnt == '0) begin
            state    <= ST_ACK;
            dsack_n  <= DSACK_CODE;
            dsack_oe <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (!strobes_on) begin
            state      <= ST_IDLE;
            data_oe_hi <= 1'b0;
            data_oe_lo <= 1'b0;
            dsack_n    <= 2'b11;
            dsack_oe   <= 1'b0;
          end
        end
      endcase
    end
  end

  // R7
  dsack_code_chk: assert property (@(posedge clk) disable iff (rst)
    dsack_oe |-> (dsack_n == DSACK_CODE));

  // R8
  data_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dsack_oe) |-> $past(data_oe_hi || data_oe_lo));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && !ds_act) |=> (!dsack_oe && !data_oe_hi && !data_oe_lo));

  // R11
  hold_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (data_oe_hi && $past(data_oe_hi)) |-> $stable(data_out[15:8]));

  // R11
  hold_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (data_oe_lo && $past(data_oe_lo)) |-> $stable(data_out[7:0]));

  // R3
  no_write_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && strobes_on && !rw) |=> !(data_oe_hi || data_oe_lo));

  if (PORT_W == 8) begin : g_narrow_chk
    // R6
    no_low_lane_chk: assert property (@(posedge clk) disable iff (rst)
      !data_oe_lo);
  end

endmodule

// File: tb/bus_read_responder_tb_top.sv
module resp_ref_model #(
  parameter int          PORT_W   = 16,
  parameter int          IDX_W    = 4,
  parameter logic [23:0] WIN_BASE = 24'h0,
  parameter logic [23:0] WIN_MASK = 24'hFFFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [23:0] addr,
  input  logic        rw,
  input  logic [1:0]  siz,
  input  logic        as_n,
  input  logic        ds_n,
  input  logic [3:0]  wait_clks,
  input  logic        ld_en,
  input  logic [3:0]  ld_idx,
  input  logic [15:0] ld_data,
  output logic        e_oe_hi,
  output logic        e_oe_lo,
  output logic        e_ack_oe,
  output logic [1:0]  e_dsack_n,
  output logic [15:0] e_data
);
  int phase;
  int remaining;
  int mem [int];
  bit qa [$];
  bit qd [$];
  bit both;
  int slot;
  int word;

  initial begin
    e_oe_hi = 0; e_oe_lo = 0; e_ack_oe = 0; e_dsack_n = 2'b11; e_data = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      phase = 0;
      remaining = 0;
      qa = '{1'b1, 1'b1};
      qd = '{1'b1, 1'b1};
      e_oe_hi = 0; e_oe_lo = 0; e_ack_oe = 0; e_dsack_n = 2'b11; e_data = 0;
    end else begin
      both = !qa[0] && !qd[0];
      if (phase == 0) begin
        if (both) begin
          if (rw && ((addr & WIN_MASK) == WIN_BASE)) begin
            phase = 2;
            remaining = int'(wait_clks);
            slot = (PORT_W == 16) ? int'((addr >> 1) & 24'hF) : int'(addr & 24'hF);
            word = mem.exists(slot) ? mem[slot] : 0;
            if (PORT_W == 16) begin
              e_data = word[15:0];
              if (siz == 2'b01) begin
                e_oe_hi = !addr[0];
                e_oe_lo = addr[0];
              end else begin
                e_oe_hi = 1; e_oe_lo = 1;
              end
            end else begin
              e_data = {word[7:0], 8'h00};
              e_oe_hi = 1; e_oe_lo = 0;
            end
          end else begin
            phase = 1;
          end
        end
      end else if (phase == 1) begin
        if (!both) phase = 0;
      end else if (phase == 2) begin
        if (!both) begin
          phase = 0; e_oe_hi = 0; e_oe_lo = 0;
        end else if (remaining == 0) begin
          phase = 3; e_ack_oe = 1;
          e_dsack_n = (PORT_W == 16) ? 2'b00 : 2'b10;
        end else begin
          remaining = remaining - 1;
        end
      end else begin
        if (!both) begin
          phase = 0; e_oe_hi = 0; e_oe_lo = 0; e_ack_oe = 0; e_dsack_n = 2'b11;
        end
      end
      void'(qa.pop_front()); qa.push_back(as_n);
      void'(qd.pop_front()); qd.push_back(ds_n);
    end
    if (ld_en) mem[int'(ld_idx)] = (PORT_W == 16) ? int'(ld_data) : int'(ld_data[7:0]);
  end
endmodule

module bus_read_responder_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [23:0] addr = 0;
  logic        rw = 1;
  logic [1:0]  siz = 2'b10;
  logic        as_n = 1;
  logic        ds_n = 1;
  logic [3:0]  wait_clks = 0;
  logic        ld_en = 0;
  logic [3:0]  ld_idx = 0;
  logic [15:0] ld_data = 0;

  logic [15:0] d16, d8, ed16, ed8;
  logic        oh16, ol16, ao16, oh8, ol8, ao8;
  logic        eoh16, eol16, eao16, eoh8, eol8, eao8;
  logic [1:0]  dk16, dk8, edk16, edk8;

  int    vectors = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    done = 0;
  string req = "R1";

  always #10 clk = ~clk;

  bus_read_responder #(
    .PORT_W(16), .WIN_BASE(24'h004000), .WIN_MASK(24'hFFFFE0)
  ) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .siz(siz), .as_n(as_n), .ds_n(ds_n),
    .wait_clks(wait_clks), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .data_out(d16), .data_oe_hi(oh16), .data_oe_lo(ol16), .dsack_n(dk16), .dsack_oe(ao16)
  );

  bus_read_responder #(
    .PORT_W(8), .WIN_BASE(24'h008000), .WIN_MASK(24'hFFFFF0)
  ) dut8_i (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .siz(siz), .as_n(as_n), .ds_n(ds_n),
    .wait_clks(wait_clks), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data[7:0]),
    .data_out(d8), .data_oe_hi(oh8), .data_oe_lo(ol8), .dsack_n(dk8), .dsack_oe(ao8)
  );

  resp_ref_model #(.PORT_W(16), .WIN_BASE(24'h004000), .WIN_MASK(24'hFFFFE0)) m16_i (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .siz(siz), .as_n(as_n), .ds_n(ds_n),
    .wait_clks(wait_clks), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .e_oe_hi(eoh16), .e_oe_lo(eol16), .e_ack_oe(eao16), .e_dsack_n(edk16), .e_data(ed16)
  );

  resp_ref_model #(.PORT_W(8), .WIN_BASE(24'h008000), .WIN_MASK(24'hFFFFF0)) m8_i (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .siz(siz), .as_n(as_n), .ds_n(ds_n),
    .wait_clks(wait_clks), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .e_oe_hi(eoh8), .e_oe_lo(eol8), .e_ack_oe(eao8), .e_dsack_n(edk8), .e_data(ed8)
  );

  task automatic compare(input string who,
                         input logic oh, input logic ol, input logic ao,
                         input logic [1:0] dk, input logic [15:0] d,
                         input logic eoh, input logic eol, input logic eao,
                         input logic [1:0] edk, input logic [15:0] ed);
    bit bad = 0;
    vectors++;
    if (oh !== eoh || ol !== eol || ao !== eao || dk !== edk) bad = 1;
    if (eoh && d[15:8] !== ed[15:8]) bad = 1;
    if (eol && d[7:0] !== ed[7:0]) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s %s t=%0t: got oe=%b%b ack_oe=%b dsack_n=%b data=%h, exp oe=%b%b ack_oe=%b dsack_n=%b data=%h",
               req, who, $time, oh, ol, ao, dk, d, eoh, eol, eao, edk, ed);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      compare("port16", oh16, ol16, ao16, dk16, d16, eoh16, eol16, eao16, edk16, ed16);
      compare("port8",  oh8,  ol8,  ao8,  dk8,  d8,  eoh8,  eol8,  eao8,  edk8,  ed8);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, exp at most 20000", cycles);
      finish_run();
    end
  end

  // One bus cycle: strobes low for 'hold' clocks, then both negated.
  task automatic bus_cycle(input string tag, input logic [23:0] a, input logic r,
                           input logic [1:0] s, input logic [3:0] w, input int hold);
    @(negedge clk);
    req = tag;
    addr = a; rw = r; siz = s; wait_clks = w;
    as_n = 0; ds_n = 0;
    repeat (hold) @(negedge clk);
    as_n = 1; ds_n = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    @(posedge clk);
    started = 1;
    // R1: reset state held for several clocks
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    req = "LOAD";
    for (int i = 0; i < 16; i++) begin
      ld_en = 1; ld_idx = 4'(i); ld_data = 16'hA53C ^ 16'(i * 16'h1357);
      @(negedge clk);
    end
    ld_en = 0;
    repeat (3) @(negedge clk);

    bus_cycle("R4", 24'h004006, 1'b1, 2'b10, 4'd0, 8);
    bus_cycle("R4", 24'h00401E, 1'b1, 2'b00, 4'd2, 10);
    bus_cycle("R4", 24'h004010, 1'b1, 2'b11, 4'd1, 9);
    bus_cycle("R5", 24'h004008, 1'b1, 2'b01, 4'd0, 8);
    bus_cycle("R5", 24'h004009, 1'b1, 2'b01, 4'd1, 8);
    bus_cycle("R6", 24'h008005, 1'b1, 2'b01, 4'd1, 8);
    bus_cycle("R6", 24'h00800F, 1'b1, 2'b10, 4'd0, 8);
    bus_cycle("R7", 24'h00800A, 1'b1, 2'b00, 4'd3, 10);
    bus_cycle("R8", 24'h004002, 1'b1, 2'b10, 4'd5, 12);
    bus_cycle("R8", 24'h00400C, 1'b1, 2'b10, 4'd15, 22);
    bus_cycle("R2", 24'h004100, 1'b1, 2'b10, 4'd0, 8);
    bus_cycle("R2", 24'h008010, 1'b1, 2'b01, 4'd0, 8);
    bus_cycle("R3", 24'h004004, 1'b0, 2'b10, 4'd0, 8);
    bus_cycle("R3", 24'h008003, 1'b0, 2'b01, 4'd0, 8);
    bus_cycle("R10", 24'h004012, 1'b1, 2'b10, 4'd12, 4);
    bus_cycle("R10", 24'h008007, 1'b1, 2'b01, 4'd9, 5);
    bus_cycle("R9", 24'h004014, 1'b1, 2'b10, 4'd1, 20);
    bus_cycle("R11", 24'h008001, 1'b1, 2'b01, 4'd8, 16);

    // R12: data strobe toggled while the address strobe stays low
    @(negedge clk);
    req = "R12";
    addr = 24'h004016; rw = 1; siz = 2'b10; wait_clks = 4'd2;
    as_n = 0; ds_n = 0;
    repeat (14) @(negedge clk);
    ds_n = 1;
    repeat (4) @(negedge clk);
    ds_n = 0;
    repeat (10) @(negedge clk);
    as_n = 1; ds_n = 1;
    repeat (6) @(negedge clk);

    // R1: reset in the middle of an acknowledged cycle
    @(negedge clk);
    req = "R1";
    addr = 24'h004018; as_n = 0; ds_n = 0; wait_clks = 0;
    repeat (6) @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    as_n = 1; ds_n = 1;
    rst = 0;
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule